// File: doc/BRIEF.md
# Data-memory access decoder

This block sits between the operand-address logic of an 8-bit microcontroller core and its data storage. For each access it takes an address and an addressing mode and names one target: core RAM (256 bytes), on-chip auxiliary RAM (1280 bytes), the special-function-register (SFR) space, or the external data bus. It also gives the physical offset inside that target. The same byte addresses 128 to 255 lead to different storage depending on the mode. Register-indirect accesses reach the upper half of core RAM. Direct accesses reach the SFRs.

External moves come in two forms. One uses a 16-bit pointer. The other uses an 8-bit pointer combined with a page register. Both are steered into the auxiliary RAM while it is enabled, and to the external bus otherwise. The block holds the page register and the auxiliary-RAM disable bit itself, and both are written as SFRs. It also resolves register-bank operands and bit addresses into byte offsets. The decode is combinational from the request inputs. Only the two SFR-mapped registers are clocked.

Top module: `dmem_decoder`

## Requirements
- R1: With `mode_i` = 0 (direct) or 1 (indirect), a byte address 0..127 in `addr_i[7:0]` selects core RAM (`sel_o` = 4'b0001) with offset equal to the address. Bits 15:8 of `addr_i` are ignored for these modes.
- R2: Addresses 128..255 select core RAM at offset = address when `mode_i` = 1. They select SFR space (`sel_o` = 4'b0100) at offset = address − 128 when `mode_i` = 0.
- R3: With `mode_i` = 4 (register operand), `addr_i[2:0]` is the register number and `bank_i` picks one of four banks of eight. Core RAM is selected at offset `bank_i`·8 + register number.
- R4: With `mode_i` = 5 (bit operand), a bit address below 128 selects core RAM byte 32 + address/8. An address of 128 or more selects the SFR at offset {`addr_i[6:3]`,3'b000}. In both cases `bit_o` = `addr_i[2:0]`. `bit_o` is 0 in all other modes.
- R5: With `mode_i` = 3 (16-bit pointer move) and the disable bit 0, addresses 0..1279 select auxiliary RAM (`sel_o` = 4'b0010) at offset = address. `ext_req_o` stays low.
- R6: With `mode_i` = 3, addresses 1280 and up select the external bus (`sel_o` = 4'b1000) at offset = address, with `ext_req_o` = 1 and `ext_we_o` = `we_i`.
- R7: With `mode_i` = 2 (paged 8-bit pointer move) and the disable bit 0, the address is {page register, `addr_i[7:0]`}. A value of 0..1279 selects auxiliary RAM at that offset.
- R8: A paged move whose combined address is 1280 or more, while the disable bit is 0, raises `oor_o`. No target is selected and `ext_req_o` stays low.
- R9: While the disable bit is 1, every move with `mode_i` = 2 or 3 selects the external bus with `ext_req_o` = 1. The offset is the full 16-bit address, which is {page, pointer} for paged moves.
- R10: After reset the page register and the disable bit are 0.
- R11: A direct write (`mode_i` = 0, `we_i` = 1) to SFR address 0xFA loads the page register with `wdata_i` at the clock edge. A direct write to 0xFB loads the disable bit from `wdata_i[0]`. Writes in any other mode leave both unchanged.
- R12: With `req_i` = 0, `sel_o`, `ext_req_o`, `ext_we_o` and `oor_o` are all 0. At most one bit of `sel_o` is ever set, and undefined modes 6 and 7 select nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request valid |
| mode_i | input | 3 | Addressing mode (0 direct, 1 indirect, 2 paged move, 3 wide move, 4 register, 5 bit) |
| addr_i | input | 16 | Access address or pointer |
| bank_i | input | 2 | Active register bank |
| we_i | input | 1 | Write access |
| wdata_i | input | 8 | Write data, used for SFR register updates |
| sel_o | output | 4 | One-hot target: bit0 core RAM, bit1 aux RAM, bit2 SFR, bit3 external |
| off_o | output | 16 | Offset inside the selected target |
| bit_o | output | 3 | Bit index for bit operands |
| ext_req_o | output | 1 | External bus strobe request |
| ext_we_o | output | 1 | External bus write direction |
| oor_o | output | 1 | Paged move outside auxiliary RAM while it is enabled |

## Verification
The out-of-range case for paged moves is the hardest to reach. It needs a page register value that only a prior direct SFR write can set, and the disable bit must still be clear. The stimulus first writes the page register to 4 and reads back location 0x4FF, the last valid location. It then moves the page to 5 so the same kind of move overflows. Next it tries an indirect write to the page address and confirms the overflow persists. Only after that does it set the disable bit, which turns the same move into an external access.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int XADDR_W = 16;
  localparam int BYTE_W  = 8;
  localparam int TGT_N   = 4;
  localparam int T_IRAM  = 0;
  localparam int T_AUX   = 1;
  localparam int T_SFR   = 2;
  localparam int T_EXT   = 3;

  typedef enum logic [2:0] {
    AM_DIRECT   = 3'd0,
    AM_INDIRECT = 3'd1,
    AM_XPAGED   = 3'd2,
    AM_XWIDE    = 3'd3,
    AM_REG      = 3'd4,
    AM_BIT      = 3'd5
  } amode_e;
endpackage

// File: rtl/dmem_sfr_regs.sv
module dmem_sfr_regs
  import dmem_pkg::*;
#(
  parameter logic [7:0] PAGE_ADDR = 8'hFA,
  parameter logic [7:0] CTL_ADDR  = 8'hFB,
  parameter int         DIS_BIT   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] page_o,
  output logic              aux_dis_o
);
  logic page_hit, ctl_hit;
  assign page_hit = wr_en_i && (wr_addr_i == PAGE_ADDR);
  assign ctl_hit  = wr_en_i && (wr_addr_i == CTL_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_o    <= '0;
      aux_dis_o <= 1'b0;
    end else begin
      if (page_hit) page_o    <= wr_data_i;
      if (ctl_hit)  aux_dis_o <= wr_data_i[DIS_BIT];
    end
  end

  // R11: load on hit, hold otherwise
  a_r11_page_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_hit |=> page_o == $past(wr_data_i));
  a_r11_page_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !page_hit |=> $stable(page_o));
  a_r11_dis_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_hit |=> $stable(aux_dis_o));
endmodule

// File: rtl/dmem_int_dec.sv
module dmem_int_dec
  import dmem_pkg::*;
#(
  parameter int BIT_BASE = 32
) (
  input  logic [2:0]         mode_i,
  input  logic [BYTE_W-1:0]  addr_i,
  input  logic [1:0]         bank_i,
  output logic [TGT_N-1:0]   sel_o,
  output logic [XADDR_W-1:0] off_o,
  output logic [2:0]         bit_o
);
  localparam logic [XADDR_W-1:0] BIT_BASE_W = XADDR_W'(BIT_BASE);

  always_comb begin
    sel_o = '0;
    off_o = '0;
    bit_o = '0;
    case (mode_i)
      AM_DIRECT: begin
        if (addr_i[7]) begin
          sel_o[T_SFR] = 1'b1;
          off_o        = XADDR_W'(addr_i[6:0]);
        end else begin
          sel_o[T_IRAM] = 1'b1;
          off_o         = XADDR_W'(addr_i);
        end
      end
      AM_INDIRECT: begin
        sel_o[T_IRAM] = 1'b1;
        off_o         = XADDR_W'(addr_i);
      end
      AM_REG: begin
        sel_o[T_IRAM] = 1'b1;
        off_o         = XADDR_W'({bank_i, addr_i[2:0]});
      end
      AM_BIT: begin
        bit_o = addr_i[2:0];
        if (addr_i[7]) begin
          sel_o[T_SFR] = 1'b1;
          off_o        = XADDR_W'({addr_i[6:3], 3'b000});
        end else begin
          sel_o[T_IRAM] = 1'b1;
          off_o         = BIT_BASE_W + XADDR_W'(addr_i[6:3]);
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dmem_ext_dec.sv
module dmem_ext_dec
  import dmem_pkg::*;
#(
  parameter int AUX_SIZE = 1280
) (
  input  logic [2:0]         mode_i,
  input  logic [XADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0]  page_i,
  input  logic               aux_dis_i,
  output logic [TGT_N-1:0]   sel_o,
  output logic [XADDR_W-1:0] off_o,
  output logic               oor_o
);
  localparam logic [XADDR_W-1:0] AUX_LIM = XADDR_W'(AUX_SIZE);

  logic               is_move, is_paged, in_aux;
  logic [XADDR_W-1:0] eff;

  assign is_paged = (mode_i == AM_XPAGED);
  assign is_move  = is_paged || (mode_i == AM_XWIDE);
  assign eff      = is_paged ? XADDR_W'({page_i, addr_i[7:0]}) : addr_i;
  assign in_aux   = eff < AUX_LIM;

  always_comb begin
    sel_o = '0;
    off_o = '0;
    oor_o = 1'b0;
    if (is_move) begin
      off_o = eff;
      if (aux_dis_i)     sel_o[T_EXT] = 1'b1;
      else if (in_aux)   sel_o[T_AUX] = 1'b1;
      else if (is_paged) begin
        oor_o = 1'b1;  // paged move cannot leave chip while aux is on
        off_o = '0;
      end
      else               sel_o[T_EXT] = 1'b1;
    end
  end
endmodule

// File: rtl/dmem_decoder.sv
module dmem_decoder
  import dmem_pkg::*;
#(
  parameter int         AUX_SIZE  = 1280,
  parameter int         BIT_BASE  = 32,
  parameter logic [7:0] PAGE_ADDR = 8'hFA,
  parameter logic [7:0] CTL_ADDR  = 8'hFB,
  parameter int         DIS_BIT   = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  input  logic [2:0]   mode_i,
  input  logic [15:0]  addr_i,
  input  logic [1:0]   bank_i,
  input  logic         we_i,
  input  logic [7:0]   wdata_i,
  output logic [3:0]   sel_o,
  output logic [15:0]  off_o,
  output logic [2:0]   bit_o,
  output logic         ext_req_o,
  output logic         ext_we_o,
  output logic         oor_o
);
  logic [BYTE_W-1:0]  page;
  logic               aux_dis;
  logic               is_move, sfr_wr;
  logic [TGT_N-1:0]   int_sel, ext_sel;
  logic [XADDR_W-1:0] int_off, ext_off;
  logic [2:0]         int_bit;
  logic               ext_oor;

  assign is_move = (mode_i == AM_XPAGED) || (mode_i == AM_XWIDE);
  assign sfr_wr  = req_i && we_i && (mode_i == AM_DIRECT);

  dmem_sfr_regs #(
    .PAGE_ADDR(PAGE_ADDR), .CTL_ADDR(CTL_ADDR), .DIS_BIT(DIS_BIT)
  ) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i  (sfr_wr),
    .wr_addr_i(addr_i[7:0]),
    .wr_data_i(wdata_i),
    .page_o   (page),
    .aux_dis_o(aux_dis)
  );

  dmem_int_dec #(.BIT_BASE(BIT_BASE)) u_int (
    .mode_i, .addr_i(addr_i[7:0]), .bank_i,
    .sel_o(int_sel), .off_o(int_off), .bit_o(int_bit)
  );

  dmem_ext_dec #(.AUX_SIZE(AUX_SIZE)) u_ext (
    .mode_i, .addr_i, .page_i(page), .aux_dis_i(aux_dis),
    .sel_o(ext_sel), .off_o(ext_off), .oor_o(ext_oor)
  );

  always_comb begin
    sel_o = '0;
    off_o = '0;
    bit_o = '0;
    oor_o = 1'b0;
    if (req_i) begin
      if (is_move) begin
        sel_o = ext_sel;
        off_o = ext_off;
        oor_o = ext_oor;
      end else begin
        sel_o = int_sel;
        off_o = int_off;
        bit_o = int_bit;
      end
    end
  end

  assign ext_req_o = sel_o[T_EXT];
  assign ext_we_o  = sel_o[T_EXT] && we_i;

  a_r12_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));
  a_r12_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (sel_o == '0) && !ext_req_o && !ext_we_o && !oor_o);
  a_r5_aux_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o[T_AUX] |-> !ext_req_o && !ext_we_o);
  a_r8_oor_nosel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oor_o |-> (sel_o == '0) && !ext_req_o);
  a_r7_paged_onchip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && (mode_i == AM_XPAGED) && !aux_dis |-> !ext_req_o);
  a_r9_dis_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && is_move && aux_dis |-> ext_req_o && !oor_o);
  a_r2_direct_sfr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && (mode_i == AM_DIRECT) && addr_i[7] |-> sel_o == 4'b0100);
endmodule

// File: tb/dmem_decoder_tb.sv
module dmem_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  mode = '0;
  logic [15:0] addr = '0;
  logic [1:0]  bank = '0;
  logic        we = 1'b0;
  logic [7:0]  wdata = '0;
  logic [3:0]  sel;
  logic [15:0] off;
  logic [2:0]  bidx;
  logic        ext_req, ext_we, oor;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  dmem_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .mode_i(mode), .addr_i(addr),
    .bank_i(bank), .we_i(we), .wdata_i(wdata), .sel_o(sel), .off_o(off),
    .bit_o(bidx), .ext_req_o(ext_req), .ext_we_o(ext_we), .oor_o(oor)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic [15:0] addr;
    logic        we;
    logic [1:0]  bank;
    logic [3:0]  sel;
    logic [15:0] off;
    logic [2:0]  bidx;
    logic        xreq;
    logic        xwe;
    logic        oor;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 16'h0045, 1'b0, 2'd0, 4'b0001, 16'h0045, 3'd0, 1'b0, 1'b0, 1'b0}, // R1
    '{3'd1, 16'h007F, 1'b1, 2'd0, 4'b0001, 16'h007F, 3'd0, 1'b0, 1'b0, 1'b0}, // R1
    '{3'd1, 16'h0080, 1'b0, 2'd0, 4'b0001, 16'h0080, 3'd0, 1'b0, 1'b0, 1'b0}, // R2
    '{3'd0, 16'h0080, 1'b0, 2'd0, 4'b0100, 16'h0000, 3'd0, 1'b0, 1'b0, 1'b0}, // R2
    '{3'd0, 16'h00FF, 1'b0, 2'd0, 4'b0100, 16'h007F, 3'd0, 1'b0, 1'b0, 1'b0}, // R2
    '{3'd0, 16'h12C3, 1'b0, 2'd0, 4'b0100, 16'h0043, 3'd0, 1'b0, 1'b0, 1'b0}, // R1 R2 high bits
    '{3'd4, 16'h0005, 1'b0, 2'd2, 4'b0001, 16'h0015, 3'd0, 1'b0, 1'b0, 1'b0}, // R3
    '{3'd4, 16'h0007, 1'b0, 2'd3, 4'b0001, 16'h001F, 3'd0, 1'b0, 1'b0, 1'b0}, // R3
    '{3'd5, 16'h0000, 1'b0, 2'd0, 4'b0001, 16'h0020, 3'd0, 1'b0, 1'b0, 1'b0}, // R4
    '{3'd5, 16'h007F, 1'b0, 2'd0, 4'b0001, 16'h002F, 3'd7, 1'b0, 1'b0, 1'b0}, // R4
    '{3'd5, 16'h0093, 1'b0, 2'd0, 4'b0100, 16'h0010, 3'd3, 1'b0, 1'b0, 1'b0}, // R4
    '{3'd3, 16'h0000, 1'b1, 2'd0, 4'b0010, 16'h0000, 3'd0, 1'b0, 1'b0, 1'b0}, // R5
    '{3'd3, 16'h04FF, 1'b0, 2'd0, 4'b0010, 16'h04FF, 3'd0, 1'b0, 1'b0, 1'b0}, // R5
    '{3'd3, 16'h0500, 1'b1, 2'd0, 4'b1000, 16'h0500, 3'd0, 1'b1, 1'b1, 1'b0}, // R6
    '{3'd3, 16'hFFFF, 1'b0, 2'd0, 4'b1000, 16'hFFFF, 3'd0, 1'b1, 1'b0, 1'b0}, // R6
    '{3'd2, 16'hAB34, 1'b0, 2'd0, 4'b0010, 16'h0034, 3'd0, 1'b0, 1'b0, 1'b0}  // R7 R10
  };

  task automatic check(input string tag, input logic [3:0] e_sel,
                       input logic [15:0] e_off, input logic [2:0] e_bit,
                       input logic e_xreq, input logic e_xwe, input logic e_oor);
    n_chk++;
    if (sel !== e_sel || off !== e_off || bidx !== e_bit ||
        ext_req !== e_xreq || ext_we !== e_xwe || oor !== e_oor) begin
      n_bad++;
      $display("FAIL %s: sel=%b off=%h bit=%0d xreq=%b xwe=%b oor=%b, expected sel=%b off=%h bit=%0d xreq=%b xwe=%b oor=%b",
               tag, sel, off, bidx, ext_req, ext_we, oor,
               e_sel, e_off, e_bit, e_xreq, e_xwe, e_oor);
    end
  endtask

  // drive at falling edge, sample combinational result shortly after
  task automatic apply(input logic [2:0] m, input logic [15:0] a,
                       input logic w, input logic [1:0] b);
    @(negedge clk);
    req = 1'b1; mode = m; addr = a; we = w; bank = b; wdata = '0;
    #2;
  endtask

  task automatic sfr_write(input logic [2:0] m, input logic [7:0] a,
                           input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; mode = m; addr = {8'h00, a}; we = 1'b1; wdata = d; bank = '0;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R12: idle after reset
    apply(3'd0, 16'h0010, 1'b0, 2'd0);
    req = 1'b0; #1;
    check("R12 idle", 4'b0000, 16'h0000, 3'd0, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].mode, VECS[i].addr, VECS[i].we, VECS[i].bank);
      check($sformatf("vector %0d", i), VECS[i].sel, VECS[i].off,
            VECS[i].bidx, VECS[i].xreq, VECS[i].xwe, VECS[i].oor);
    end

    // R12: undefined mode selects nothing
    apply(3'd6, 16'h0010, 1'b1, 2'd0);
    check("R12 mode6", 4'b0000, 16'h0000, 3'd0, 1'b0, 1'b0, 1'b0);

    // R11: page register load, then last valid paged location
    sfr_write(3'd0, 8'hFA, 8'h04);
    apply(3'd2, 16'h00FF, 1'b0, 2'd0);
    check("R7 paged top", 4'b0010, 16'h04FF, 3'd0, 1'b0, 1'b0, 1'b0);

    sfr_write(3'd0, 8'hFA, 8'h05);
    apply(3'd2, 16'h0000, 1'b1, 2'd0);
    check("R8 paged oor", 4'b0000, 16'h0000, 3'd0, 1'b0, 1'b0, 1'b1);

    // R11: indirect write to page address must not load it
    sfr_write(3'd1, 8'hFA, 8'h02);
    apply(3'd2, 16'h0000, 1'b0, 2'd0);
    check("R11 indirect ignored", 4'b0000, 16'h0000, 3'd0, 1'b0, 1'b0, 1'b1);

    // R11 / R9: set disable bit
    sfr_write(3'd0, 8'hFB, 8'h01);
    apply(3'd2, 16'h0000, 1'b1, 2'd0);
    check("R9 paged ext", 4'b1000, 16'h0500, 3'd0, 1'b1, 1'b1, 1'b0);
    apply(3'd3, 16'h0010, 1'b0, 2'd0);
    check("R9 wide ext", 4'b1000, 16'h0010, 3'd0, 1'b1, 1'b0, 1'b0);

    sfr_write(3'd0, 8'hFA, 8'h00);
    apply(3'd2, 16'h0010, 1'b0, 2'd0);
    check("R9 paged low ext", 4'b1000, 16'h0010, 3'd0, 1'b1, 1'b0, 1'b0);

    // R11: clearing disable restores aux
    sfr_write(3'd0, 8'hFB, 8'hFE);
    apply(3'd3, 16'h0010, 1'b0, 2'd0);
    check("R11 dis cleared", 4'b0010, 16'h0010, 3'd0, 1'b0, 1'b0, 1'b0);

    // R10: reset clears page and disable
    sfr_write(3'd0, 8'hFA, 8'h07);
    sfr_write(3'd0, 8'hFB, 8'h01);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    apply(3'd2, 16'h0010, 1'b0, 2'd0);
    check("R10 reset page/dis", 4'b0010, 16'h0010, 3'd0, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule